// File: doc/BRIEF.md
# SPI NAND Page Reader with ECC Check

This block fetches data from one page of a serial NAND device. It drives the SPI pins itself. A transaction has three steps. First it issues an array-to-cache load for a 24-bit row address. Then it polls the device status register until the device is ready, and takes the on-die ECC verdict from that status byte. Last it reads the requested bytes out of the device cache, on four data lines or on one. The bytes leave the block on a valid/ready stream. The block holds the serial clock still while the consumer stalls, so no byte is ever lost.

A second mode checks the bad-block marker. The block loads the page and reads one spare byte. When the row is the first page of a block and its marker is clean, the block checks the following page as well. When a transaction ends, `done` pulses for one cycle. The flags `ecc_error`, `timeout` and `bad_block` are valid in the `done` cycle and keep their values until the next accepted start.

Top module: `snand_page_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `out_valid` is 0, `done` is 0 and `busy` is 0.
- R2: Each transaction begins with a load frame: byte 0x13, then the 24-bit row address, most significant bit first on `spi_dq_o[0]`. Data changes while the clock is low and is sampled on the rising edge.
- R3: After the load, the block repeats a status frame (bytes 0x0F, 0xC0, then one byte received on `spi_dq_i[1]`) for as long as status bit 0 (busy) is 1. No cache read is issued while the device reports busy.
- R4: Bits 5:4 of the first status byte that shows ready hold the ECC code. Codes 0 and 1 leave `ecc_error` at 0. Codes 2 and 3 set it to 1. The data is still delivered, and the flag is valid with `done`.
- R5: With `use_quad`=1, the cache read sends opcode `QUAD_OP` (default 0x6B) and the 16-bit column on one line. It then spends `DUMMY_CYC` (default 8) clock cycles idle, and receives each byte on `spi_dq_i[3:0]`, high nibble first. Bytes come out in ascending column order, and `spi_dq_oe` is 0 while they arrive.
- R6: With `use_quad`=0, the cache read sends 0x03, the 16-bit column and 0x00. It then receives each byte most significant bit first on `spi_dq_i[1]`.
- R7: When `out_valid` is 1 and `out_ready` is 0, `out_data` and `spi_sclk` hold their values in the next cycle. Every byte is delivered exactly once.
- R8: A read with `byte_count`=0 issues no cache read and ends after the status poll.
- R9: When `MAX_POLLS` status frames have all reported busy, the block ends with `timeout`=1. It then issues no cache read and delivers no bytes.
- R10: With `check_bad`=1, the block reads one byte at column `SPARE_COL` (default 0x800) with the single-line read of R6, after the load and poll. It streams no data. A value other than 0xFF sets `bad_block`=1.
- R11: In that mode, when the row is a multiple of `PAGE_BLK` (default 64) and its marker reads 0xFF, the block loads and checks row+1 in the same way. Any other row is checked alone.
- R12: `done` is a single-cycle pulse with `busy`=0. The flags are stable from `done` until the next start. A `start` while `busy` is 1 is ignored.
- R13: `spi_sclk` is 0 and `spi_dq_oe` is 0 whenever `spi_cs_n` is 1. Chip select goes high for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| check_bad | input | 1 | 1 selects the bad-block marker check |
| use_quad | input | 1 | 1 selects the four-line cache read |
| row_addr | input | 24 | Page (row) address |
| col_addr | input | 16 | First column of the read |
| byte_count | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle completion pulse |
| ecc_error | output | 1 | Uncorrectable ECC code seen |
| timeout | output | 1 | Device stayed busy for MAX_POLLS polls |
| bad_block | output | 1 | Marker check found a bad block |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dq_o | output | 4 | Data lines driven by the block |
| spi_dq_oe | output | 4 | Per-line output enable |
| spi_dq_i | input | 4 | Data lines from the device |

## Verification
The last byte of a read can be waiting in the output register while the read frame closes. The completion logic must then hold `done` back until that byte is taken, and must present the ECC verdict from the earlier status poll in the same cycle as `done`. The bench sets this up two ways. It drives ready low through the final bytes of a quad read, and it runs reads with ECC code 2 while ready follows a pseudo-random pattern. It then checks that the scoreboard queue is empty and that `ecc_error` is 1 in the cycle where `done` is first seen. A separate case holds ready low in the middle of a stream and confirms that the serial clock stops toggling until ready returns.

// File: rtl/snand_page_reader.sv
module snand_page_reader #(
  parameter logic [7:0]  QUAD_OP   = 8'h6B,
  parameter int          DUMMY_CYC = 8,
  parameter int          MAX_POLLS = 4096,
  parameter int          LEN_W     = 16,
  parameter int          PAGE_BLK  = 64,
  parameter logic [15:0] SPARE_COL = 16'h0800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             check_bad,
  input  logic             use_quad,
  input  logic [23:0]      row_addr,
  input  logic [15:0]      col_addr,
  input  logic [LEN_W-1:0] byte_count,
  output logic             busy,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             ecc_error,
  output logic             timeout,
  output logic             bad_block,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic [3:0]       spi_dq_o,
  output logic [3:0]       spi_dq_oe,
  input  logic [3:0]       spi_dq_i
);
  localparam int DW = $clog2(DUMMY_CYC + 2);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int BW = $clog2(PAGE_BLK);

  localparam logic [1:0] ST_IDLE = 2'd0, ST_GAP = 2'd1, ST_XFER = 2'd2, ST_FIN = 2'd3;
  localparam logic [1:0] FR_LOAD = 2'd0, FR_POLL = 2'd1, FR_READ = 2'd2, FR_MARK = 2'd3;

  logic [1:0]       st, fr;
  logic [23:0]      row_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q, rx_left;
  logic             mark_q, quad_q, second_q, rx_quad;
  logic [31:0]      tx_sr;
  logic [5:0]       tx_bits;
  logic [DW-1:0]    dum_left;
  logic [2:0]       rx_step;
  logic [7:0]       rx_sr, mark_byte;
  logic             stat_busy, stat_bad_ecc;
  logic [PW-1:0]    polls;
  logic             sck, cs_n;

  wire sending   = tx_bits != 6'd0;
  wire dummying  = !sending && dum_left != '0;
  wire receiving = !sending && !dummying && rx_left != '0;
  wire frame_end = st == ST_XFER && !sck && !sending && !dummying && !receiving;
  wire stall     = receiving && fr == FR_READ && out_valid && !out_ready;
  wire [7:0] rx_next = rx_quad ? {rx_sr[3:0], spi_dq_i} : {rx_sr[6:0], spi_dq_i[1]};
  wire byte_last = rx_quad ? rx_step[0] : (rx_step == 3'd7);
  wire rx_done   = st == ST_XFER && sck && !sending && !dummying && byte_last;
  wire first_pg  = row_q[BW-1:0] == '0;

  assign busy      = st != ST_IDLE;
  assign spi_sclk  = sck;
  assign spi_cs_n  = cs_n;
  assign spi_dq_o  = {3'b000, sending ? tx_sr[31] : 1'b0};
  assign spi_dq_oe = (cs_n || (receiving && rx_quad)) ? 4'b0000 : 4'b0001;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
    end else if (rx_done && fr == FR_READ) begin
      out_valid <= 1'b1;
      out_data  <= rx_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; fr <= FR_LOAD;
      row_q <= '0; col_q <= '0; len_q <= '0;
      mark_q <= 1'b0; quad_q <= 1'b0; second_q <= 1'b0; rx_quad <= 1'b0;
      tx_sr <= '0; tx_bits <= '0; dum_left <= '0; rx_left <= '0;
      rx_step <= '0; rx_sr <= '0; mark_byte <= '0;
      stat_busy <= 1'b0; stat_bad_ecc <= 1'b0; polls <= '0;
      sck <= 1'b0; cs_n <= 1'b1;
      done <= 1'b0; ecc_error <= 1'b0; timeout <= 1'b0; bad_block <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          row_q <= row_addr; col_q <= col_addr; len_q <= byte_count;
          mark_q <= check_bad; quad_q <= use_quad; second_q <= 1'b0;
          ecc_error <= 1'b0; timeout <= 1'b0; bad_block <= 1'b0;
          fr <= FR_LOAD; st <= ST_GAP;
        end
        ST_GAP: begin
          cs_n <= 1'b0; sck <= 1'b0; rx_step <= '0;
          dum_left <= '0; rx_quad <= 1'b0; st <= ST_XFER;
          case (fr)
            FR_LOAD: begin
              tx_sr <= {8'h13, row_q}; tx_bits <= 6'd32; rx_left <= '0;
            end
            FR_POLL: begin
              tx_sr <= {16'h0FC0, 16'h0000}; tx_bits <= 6'd16; rx_left <= LEN_W'(1);
            end
            FR_READ: begin
              rx_left <= len_q;
              if (quad_q) begin
                tx_sr <= {QUAD_OP, col_q, 8'h00}; tx_bits <= 6'd24;
                dum_left <= DW'(DUMMY_CYC); rx_quad <= 1'b1;
              end else begin
                tx_sr <= {8'h03, col_q, 8'h00}; tx_bits <= 6'd32;
              end
            end
            default: begin
              tx_sr <= {8'h03, SPARE_COL, 8'h00}; tx_bits <= 6'd32; rx_left <= LEN_W'(1);
            end
          endcase
        end
        ST_XFER: begin
          if (frame_end) begin
            cs_n <= 1'b1;
            case (fr)
              FR_LOAD: begin
                fr <= FR_POLL; polls <= '0; st <= ST_GAP;
              end
              FR_POLL: begin
                polls <= polls + 1'b1;
                if (stat_busy) begin
                  if (polls == PW'(MAX_POLLS - 1)) begin
                    timeout <= 1'b1; st <= ST_FIN;
                  end else st <= ST_GAP;
                end else begin
                  if (stat_bad_ecc) ecc_error <= 1'b1;
                  if (mark_q) begin
                    fr <= FR_MARK; st <= ST_GAP;
                  end else if (len_q == '0) st <= ST_FIN;
                  else begin
                    fr <= FR_READ; st <= ST_GAP;
                  end
                end
              end
              FR_READ: st <= ST_FIN;
              default: begin
                if (mark_byte != 8'hFF) begin
                  bad_block <= 1'b1; st <= ST_FIN;
                end else if (first_pg && !second_q) begin
                  second_q <= 1'b1; row_q <= row_q + 24'd1;
                  fr <= FR_LOAD; st <= ST_GAP;
                end else st <= ST_FIN;
              end
            endcase
          end else if (!sck) begin
            if (!stall) sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (sending) begin
              tx_sr <= {tx_sr[30:0], 1'b0};
              tx_bits <= tx_bits - 6'd1;
            end else if (dummying) begin
              dum_left <= dum_left - 1'b1;
            end else begin
              rx_sr <= rx_next;
              rx_step <= rx_step + 3'd1;
              if (byte_last) begin
                rx_step <= '0;
                rx_left <= rx_left - 1'b1;
                if (fr == FR_POLL) begin
                  stat_busy <= rx_next[0];
                  stat_bad_ecc <= rx_next[5];
                end
                if (fr == FR_MARK) mark_byte <= rx_next;
              end
            end
          end
        end
        default: if (!out_valid) begin
          done <= 1'b1; st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

module snand_page_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       ecc_error,
  input logic       timeout,
  input logic       bad_block,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic [3:0] spi_dq_oe
);
  assert_sclk_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_oe_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_dq_oe == 4'b0000);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(spi_sclk)));
  assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ecc_error) && $stable(timeout) && $stable(bad_block)));
  assert_timeout_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !out_valid);
endmodule

bind snand_page_reader snand_page_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .done(done), .ecc_error(ecc_error),
  .timeout(timeout), .bad_block(bad_block), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_dq_oe(spi_dq_oe)
);

// File: tb/sim_snand_page_reader.sv
module sim_snand_page_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, check_bad = 0, use_quad = 0, out_ready = 1;
  logic [23:0] row_addr = 0;
  logic [15:0] col_addr = 0, byte_count = 0;
  logic busy, out_valid, done, ecc_error, timeout, bad_block, spi_sclk, spi_cs_n;
  logic [7:0] out_data;
  logic [3:0] spi_dq_o, spi_dq_oe;
  logic [3:0] spi_dq_i = 4'hF;

  snand_page_reader #(.MAX_POLLS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .check_bad(check_bad), .use_quad(use_quad),
    .row_addr(row_addr), .col_addr(col_addr), .byte_count(byte_count), .busy(busy),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .done(done),
    .ecc_error(ecc_error), .timeout(timeout), .bad_block(bad_block), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_dq_o(spi_dq_o), .spi_dq_oe(spi_dq_oe), .spi_dq_i(spi_dq_i));

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R5";

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [23:0] r, input logic [15:0] c);
    if (c >= 16'h0800) return (r == 24'd128) ? 8'h00 : (r == 24'd193) ? 8'hF0 : 8'hFF;
    return ((r[7:0] * 8'd3) + c[7:0]) ^ {4'h0, c[11:8]};
  endfunction

  // device model
  int busy_cfg = 0, busy_left = 0, nbits = 0, idx = 0;
  logic [1:0] ecc_cfg = 0;
  logic [31:0] shin = 0;
  logic [7:0] cmd = 0, stat = 0, b = 0;
  logic [23:0] crow = 0, last_row = 0;
  logic [15:0] ccol = 0, last_col = 0;
  int n_load = 0, n_poll = 0, n_quad = 0, n_single = 0, proto_err = 0, cs_sclk_err = 0;

  always @(negedge spi_cs_n) nbits = 0;
  always @(posedge spi_cs_n) if (spi_sclk) cs_sclk_err++;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shin = {shin[30:0], spi_dq_o[0]};
    nbits++;
    if (nbits == 8) begin
      cmd = shin[7:0];
      if ((cmd == 8'h03 || cmd == 8'h6B) && busy_left > 0) proto_err++;
    end
    if (nbits == 16 && cmd == 8'h0F) begin
      n_poll++;
      if (shin[7:0] != 8'hC0) proto_err++;
      stat = {2'b00, ecc_cfg, 3'b000, busy_left > 0};
      if (busy_left > 0) busy_left--;
    end
    if (nbits == 32 && cmd == 8'h13) begin
      n_load++; crow = shin[23:0]; last_row = crow; busy_left = busy_cfg;
    end
    if (nbits == 24 && (cmd == 8'h03 || cmd == 8'h6B)) begin
      ccol = shin[15:0]; last_col = ccol;
      if (cmd == 8'h03) n_single++; else n_quad++;
    end
    if (nbits == 32 && cmd == 8'h03 && shin[7:0] != 8'h00) proto_err++;
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (cmd == 8'h0F && nbits >= 16 && nbits < 24) spi_dq_i[1] = stat[7 - (nbits - 16)];
    else if (cmd == 8'h03 && nbits >= 32) begin
      idx = nbits - 32; b = mem(crow, ccol + 16'(idx / 8)); spi_dq_i[1] = b[7 - (idx % 8)];
    end else if (cmd == 8'h6B && nbits >= 32) begin
      idx = nbits - 32; b = mem(crow, ccol + 16'(idx / 2));
      spi_dq_i = (idx % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  // ready pattern: 0 always, 1 pseudo-random, 2 held low
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] e;
  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    if (exp_q.size() == 0) check(1'b0, "R7", "unexpected byte", out_data, 0);
    else begin
      e = exp_q.pop_front();
      check(out_data == e, cur_req, "stream byte", out_data, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic launch(input bit mark, input bit quad, input logic [23:0] row,
                        input logic [15:0] col, input int len, input int bsy, input logic [1:0] ecc);
    busy_cfg = bsy; ecc_cfg = ecc;
    n_load = 0; n_poll = 0; n_quad = 0; n_single = 0;
    if (!mark && bsy < 12)
      for (int i = 0; i < len; i++) exp_q.push_back(mem(row, col + 16'(i)));
    @(posedge clk); #1;
    start = 1; check_bad = mark; use_quad = quad; row_addr = row; col_addr = col; byte_count = 16'(len);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic post(input string req, input int ecc_exp, input int to_exp, input int bad_exp);
    check(ecc_error == ecc_exp, "R4", "ecc_error at done", ecc_error, ecc_exp);
    check(timeout == to_exp, "R9", "timeout at done", timeout, to_exp);
    check(bad_block == bad_exp, "R10", "bad_block at done", bad_block, bad_exp);
    check(exp_q.size() == 0, req, "bytes left in queue", exp_q.size(), 0);
    check(proto_err == 0, "R3", "protocol errors", proto_err, 0);
  endtask

  int bad_cnt;
  logic s0;

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0, "R1", "spi idle in reset", {spi_cs_n, spi_sclk}, 2);
    check(!out_valid && !done && !busy, "R1", "outputs in reset", {out_valid, done, busy}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && spi_cs_n, "R1", "idle after reset", {busy, spi_cs_n}, 1);

    // quad read, two busy polls
    cur_req = "R5";
    launch(0, 1, 24'd5, 16'h0010, 16, 2, 2'd0); wait_done();
    post("R5", 0, 0, 0);
    check(n_load == 1 && last_row == 24'd5, "R2", "load row", last_row, 5);
    check(n_poll == 3, "R3", "poll count", n_poll, 3);
    check(n_quad == 1 && n_single == 0 && last_col == 16'h0010, "R5", "quad read col", last_col, 16'h10);

    // single-line read, ECC code 1 acceptable, random ready
    cur_req = "R6"; rdy_mode = 1;
    launch(0, 0, 24'h012345, 16'h07F0, 12, 0, 2'd1); wait_done();
    post("R6", 0, 0, 0);
    check(n_single == 1 && n_quad == 0 && last_row == 24'h012345, "R6", "single read issued", n_single, 1);

    // ECC code 2 with data still delivered, random ready
    cur_req = "R4";
    launch(0, 1, 24'd77, 16'h0100, 20, 1, 2'd2); wait_done();
    post("R4", 1, 0, 0);
    cur_req = "R4";
    launch(0, 0, 24'd78, 16'h0004, 3, 0, 2'd3); wait_done();
    post("R4", 1, 0, 0);

    // last bytes stalled at frame end: done waits, ECC reported with done
    rdy_mode = 2; cur_req = "R7";
    launch(0, 1, 24'd9, 16'h0020, 4, 0, 2'd2);
    repeat (200) @(negedge clk);
    check(!done && busy && out_valid, "R7", "done held while byte waits", {done, busy, out_valid}, 3'b011);
    rdy_mode = 0; wait_done();
    post("R7", 1, 0, 0);

    // stall mid-stream: clock frozen
    rdy_mode = 2; cur_req = "R7";
    launch(0, 1, 24'd300, 16'h0200, 8, 0, 2'd0);
    while (!out_valid) @(negedge clk);
    s0 = spi_sclk; bad_cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (spi_sclk != s0 || !out_valid) bad_cnt++;
    end
    check(bad_cnt == 0, "R7", "sclk frozen during stall", bad_cnt, 0);
    rdy_mode = 1; wait_done();
    post("R7", 0, 0, 0);
    rdy_mode = 0;

    // zero length
    launch(0, 1, 24'd11, 16'h0000, 0, 1, 2'd0); wait_done();
    post("R8", 0, 0, 0);
    check(n_quad + n_single == 0 && n_poll == 2, "R8", "no cache read", n_quad + n_single, 0);

    // timeout
    launch(0, 1, 24'd12, 16'h0000, 5, 1000, 2'd0); wait_done();
    post("R9", 0, 1, 0);
    check(n_poll == 12 && n_quad == 0, "R9", "polls before timeout", n_poll, 12);
    // boundary: ready on the last allowed poll
    cur_req = "R9";
    launch(0, 1, 24'd13, 16'h0030, 2, 11, 2'd0); wait_done();
    post("R9", 0, 0, 0);
    check(n_poll == 12 && n_quad == 1, "R9", "ready on last poll", n_poll, 12);

    // bad-block checks
    launch(1, 0, 24'd70, 16'h0000, 0, 1, 2'd0); wait_done();
    post("R10", 0, 0, 0);
    check(n_load == 1 && n_single == 1 && last_col == 16'h0800, "R10", "marker read col", last_col, 16'h800);
    launch(1, 1, 24'd128, 16'h0000, 0, 0, 2'd0); wait_done();
    post("R10", 0, 0, 1);
    check(n_load == 1 && n_quad == 0, "R11", "bad first page stops", n_load, 1);
    launch(1, 0, 24'd192, 16'h0000, 0, 0, 2'd0); wait_done();
    post("R11", 0, 0, 1);
    check(n_load == 2 && last_row == 24'd193, "R11", "second page checked", last_row, 193);
    launch(1, 0, 24'd256, 16'h0000, 0, 2, 2'd0); wait_done();
    post("R11", 0, 0, 0);
    check(n_load == 2 && last_row == 24'd257, "R11", "good block two pages", n_load, 2);

    // start ignored while busy; flags held after done
    cur_req = "R12";
    launch(0, 1, 24'd40, 16'h0000, 4, 3, 2'd3);
    repeat (5) @(negedge clk);
    start = 1; row_addr = 24'd999; byte_count = 16'd50;
    @(negedge clk); start = 0;
    wait_done();
    post("R12", 1, 0, 0);
    check(n_load == 1 && last_row == 24'd40, "R12", "start ignored while busy", last_row, 40);
    repeat (10) @(negedge clk);
    check(ecc_error == 1 && !done && !busy, "R12", "flags held after done", ecc_error, 1);
    check(cs_sclk_err == 0, "R13", "sclk low at cs rise", cs_sclk_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule